// File: doc/BRIEF.md
# Interrupt Flag and Wake Controller

This block collects the interrupt events of a small microcontroller and turns them into one interrupt request for the CPU and one wake-from-sleep request. It has three core sources: an external pin whose active edge is chosen by software, the wrap of an 8-bit timer from its maximum count back to zero, and a port-change pulse supplied by a neighbouring detector. A vector of peripheral event pulses forms a fourth group. Every event sets a sticky flag. Flags and enables are held in four small registers that a bus master can reach with set-mask and clear-mask writes.

A flagged source raises the CPU request only if three conditions hold: its own enable is set, the peripheral group enable is set (this applies to peripheral sources only), and the global enable is set. The wake output needs only the individual enable. A sleeping core therefore wakes even with interrupts globally off, and then continues in line instead of vectoring. Hardware only ever sets flags. Software must clear each flag by a write before it re-arms the source.

Top module: `irq_flag_ctrl`

Register map, selected by `bus_addr`:
- 0: control. bit0 global enable, bit1 peripheral group enable, bit2 edge select (1 means rising, 0 means falling), bit3 external enable, bit4 timer enable, bit5 port-change enable.
- 1: core flags. bit0 external, bit1 timer, bit2 port change.
- 2: peripheral enables. Bit i belongs to peripheral i.
- 3: peripheral flags. Bit i belongs to peripheral i.

A write with `bus_op`=1 ORs `bus_wdata` into the addressed register. A write with `bus_op`=0 clears every bit where `bus_wdata` has a 1.

## Requirements
- R1: After reset, all four registers read 0, and `irq_req` and `wake_req` are low.
- R2: With the edge select at 1, a 0-to-1 change on `ext_pin` sets core flag bit0 at the third rising clock edge after the change. A 1-to-0 change leaves the flag clear.
- R3: With the edge select at 0, a 1-to-0 change on `ext_pin` sets core flag bit0. A 0-to-1 change leaves it clear. Changing the select while the pin is steady sets nothing.
- R4: When `tmr_cnt` moves from 0xFF to 0x00 between two clock edges, core flag bit1 is set at the second of those edges. No other transition sets it, including 0xFF to 0x01.
- R5: A pulse on `port_chg` sets core flag bit2. A pulse on `periph_evt[i]` sets peripheral flag bit i. Both take effect at the clock edge that samples the pulse.
- R6: Flags are set whatever the state of the enables. They stay set until a clear-mask write. A set-mask write can also set them.
- R7: If a clear-mask write and a setting event hit the same flag in the same cycle, the flag ends set.
- R8: `irq_req` follows the register contents in the same cycle. Its value is global enable AND (any core flag with its enable OR (peripheral group enable AND any peripheral flag with its enable)).
- R9: `wake_req` is high while any flag, core or peripheral, has its own enable set. The global enable and the group enable do not affect it.
- R10: `bus_rdata` shows the register selected by `bus_addr` one clock edge after the address is presented, zero-extended to the data width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| tmr_cnt | input | 8 | Current count of the 8-bit timer |
| port_chg | input | 1 | Port-change event pulse |
| periph_evt | input | 8 | Peripheral event pulses, one per source |
| bus_wr | input | 1 | Write strobe |
| bus_op | input | 1 | 1: set bits in mask, 0: clear bits in mask |
| bus_addr | input | 2 | Register select for write and read |
| bus_wdata | input | 8 | Write mask |
| bus_rdata | output | 8 | Registered read data |
| irq_req | output | 1 | Interrupt request to the CPU |
| wake_req | output | 1 | Wake-from-sleep request |

## Verification
The hardest case to reach from the ports is a clear-mask write that lands in the same clock cycle as an event on the same flag. The bench first sets the port-change flag. It then drives the clear write and a new `port_chg` pulse on the same falling edge, so both are sampled by one rising edge. It reads the flag back afterwards, then repeats the clear alone to show that the write path works. The synchronizer latency is pinned down by sampling `wake_req` after each of the three edges that follow a pin change. The timer near-miss case (0xFF to 0x01) is driven just before the true wrap.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam logic [1:0] A_CTL  = 2'd0;
  localparam logic [1:0] A_CORE = 2'd1;
  localparam logic [1:0] A_PEN  = 2'd2;
  localparam logic [1:0] A_PFLG = 2'd3;

  localparam int CTL_GBL   = 0;
  localparam int CTL_PGRP  = 1;
  localparam int CTL_RISE  = 2;
  localparam int CTL_EXTEN = 3;
  localparam int CTL_TMREN = 4;
  localparam int CTL_CHGEN = 5;
  localparam int CTL_W     = 6;

  localparam int FLG_EXT = 0;
  localparam int FLG_TMR = 1;
  localparam int FLG_CHG = 2;
  localparam int CORE_W  = 3;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  output logic edge_hit,
  output logic sync_lvl
);
  logic ff1, ff2, prev;

  function automatic logic edge_match(input logic cur, input logic old, input logic rise);
    return rise ? (cur & ~old) : (~cur & old);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff1  <= 1'b0;
      ff2  <= 1'b0;
      prev <= 1'b0;
    end else begin
      ff1  <= pin;
      ff2  <= ff1;
      prev <= ff2;
    end
  end

  assign sync_lvl = ff2;
  assign edge_hit = edge_match(ff2, prev, rise_sel);

  // R2: a rising-mode hit only with the synchronized level high
  assert_rise_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit && rise_sel) |-> sync_lvl);
  // R3: a falling-mode hit only with the synchronized level low
  assert_fall_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit && !rise_sel) |-> !sync_lvl);
endmodule

// File: rtl/irq_wrap_det.sv
module irq_wrap_det #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] cnt,
  output logic          wrap
);
  logic [TW-1:0] cnt_prev;

  function automatic logic wrap_seen(input logic [TW-1:0] old, input logic [TW-1:0] cur);
    return (old == {TW{1'b1}}) && (cur == {TW{1'b0}});
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_prev <= '0;
    else        cnt_prev <= cnt;
  end

  assign wrap = wrap_seen(cnt_prev, cnt);

  // R4: a wrap pulse never repeats on the next cycle unless the count wrapped again
  assert_wrap_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (!wrap || $past(cnt) != cnt));
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hit,
  input  logic         wr_set,
  input  logic [W-1:0] wr_mask,
  input  logic [W-1:0] evt,
  output logic [W-1:0] q
);
  function automatic logic [W-1:0] next_bits(
    input logic [W-1:0] cur, input logic hit, input logic set,
    input logic [W-1:0] mask, input logic [W-1:0] ev);
    logic [W-1:0] base;
    if (!hit)     base = cur;
    else if (set) base = cur | mask;
    else          base = cur & ~mask;
    return base | ev;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= next_bits(q, wr_hit, wr_set, wr_mask, evt);
  end

  // R7: any bit hit by an event is set next cycle, even under a clear write
  assert_evt_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((q & $past(evt)) == $past(evt)));
  // R6: without a clear write no bit falls
  assert_no_hw_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_hit && !wr_set) |=> ((q & $past(q)) == $past(q)));
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int NPER = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      core_flg,
  input  logic [2:0]      core_en,
  input  logic            gbl_en,
  input  logic            pgrp_en,
  input  logic [NPER-1:0] per_flg,
  input  logic [NPER-1:0] per_en,
  output logic            irq,
  output logic            wake
);
  logic core_any, per_any;

  function automatic logic any_armed(input logic [NPER-1:0] f, input logic [NPER-1:0] e);
    return |(f & e);
  endfunction

  assign core_any = |(core_flg & core_en);
  assign per_any  = any_armed(per_flg, per_en);
  assign wake     = core_any | per_any;
  assign irq      = gbl_en & (core_any | (pgrp_en & per_any));

  // R8: no request with the global gate shut
  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> gbl_en);
  // R9: every request is also a wake condition
  assert_irq_wakes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> wake);
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
  parameter int DW   = 8,
  parameter int NPER = 8,
  parameter int TW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_pin,
  input  logic [TW-1:0]   tmr_cnt,
  input  logic            port_chg,
  input  logic [NPER-1:0] periph_evt,
  input  logic            bus_wr,
  input  logic            bus_op,
  input  logic [1:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq_req,
  output logic            wake_req
);
  import irq_pkg::*;

  logic [CTL_W-1:0]  ctl_q;
  logic [CORE_W-1:0] core_q;
  logic [NPER-1:0]   pen_q, pflg_q;
  logic              ext_edge, ext_lvl, tmr_wrap;
  logic [CORE_W-1:0] core_evt;
  logic [DW-1:0]     rd_next;

  irq_edge_sync u_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .rise_sel(ctl_q[CTL_RISE]),
    .edge_hit(ext_edge), .sync_lvl(ext_lvl));

  irq_wrap_det #(.TW(TW)) u_wrap (
    .clk(clk), .rst_n(rst_n), .cnt(tmr_cnt), .wrap(tmr_wrap));

  assign core_evt = {port_chg, tmr_wrap, ext_edge};

  irq_flag_bank #(.W(CTL_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_hit(bus_wr && bus_addr == A_CTL), .wr_set(bus_op),
    .wr_mask(bus_wdata[CTL_W-1:0]), .evt('0), .q(ctl_q));

  irq_flag_bank #(.W(CORE_W)) u_core (
    .clk(clk), .rst_n(rst_n), .wr_hit(bus_wr && bus_addr == A_CORE), .wr_set(bus_op),
    .wr_mask(bus_wdata[CORE_W-1:0]), .evt(core_evt), .q(core_q));

  irq_flag_bank #(.W(NPER)) u_pen (
    .clk(clk), .rst_n(rst_n), .wr_hit(bus_wr && bus_addr == A_PEN), .wr_set(bus_op),
    .wr_mask(bus_wdata[NPER-1:0]), .evt('0), .q(pen_q));

  irq_flag_bank #(.W(NPER)) u_pflg (
    .clk(clk), .rst_n(rst_n), .wr_hit(bus_wr && bus_addr == A_PFLG), .wr_set(bus_op),
    .wr_mask(bus_wdata[NPER-1:0]), .evt(periph_evt), .q(pflg_q));

  irq_combine #(.NPER(NPER)) u_comb (
    .clk(clk), .rst_n(rst_n), .core_flg(core_q),
    .core_en({ctl_q[CTL_CHGEN], ctl_q[CTL_TMREN], ctl_q[CTL_EXTEN]}),
    .gbl_en(ctl_q[CTL_GBL]), .pgrp_en(ctl_q[CTL_PGRP]),
    .per_flg(pflg_q), .per_en(pen_q), .irq(irq_req), .wake(wake_req));

  always_comb begin
    case (bus_addr)
      A_CTL:   rd_next = DW'(ctl_q);
      A_CORE:  rd_next = DW'(core_q);
      A_PEN:   rd_next = DW'(pen_q);
      default: rd_next = DW'(pflg_q);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_next;
  end

  // R4: a timer wrap leaves the timer flag set
  assert_tmr_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_wrap |=> core_q[FLG_TMR]);
  // R2: a detected pin edge leaves the external flag set
  assert_ext_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ext_edge |=> core_q[FLG_EXT]);
  // R10: read data follows the previously presented address
  assert_read_path_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_CTL && !bus_wr) |=> (bus_rdata == DW'($past(ctl_q))));
  // R2: the edge detector only fires after the pin level actually moved
  assert_lvl_moved_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ext_edge |-> (ext_lvl != $past(ext_lvl)));
endmodule

// File: tb/irq_flag_ctrl_tb.sv
module irq_flag_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_pin = 1'b0;
  logic [7:0] tmr_cnt = 8'h00;
  logic       port_chg = 1'b0;
  logic [7:0] periph_evt = 8'h00;
  logic       bus_wr = 1'b0;
  logic       bus_op = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq_req, wake_req;
  int         vectors = 0;
  int         miscompares = 0;

  localparam logic [7:0] C_GBL = 8'h01, C_PGRP = 8'h02, C_RISE = 8'h04;
  localparam logic [7:0] C_EXT = 8'h08, C_TMR = 8'h10, C_CHG = 8'h20;

  always #5 clk = ~clk;

  irq_flag_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr_cnt(tmr_cnt),
    .port_chg(port_chg), .periph_evt(periph_evt), .bus_wr(bus_wr), .bus_op(bus_op),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .wake_req(wake_req));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic op, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_op = op; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk); #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 irq", {7'd0, irq_req}, 8'h00);
    chk("R1 wake", {7'd0, wake_req}, 8'h00);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk("R1 reg", v, 8'h00);
    end
  endtask

  task automatic t_ext_rise;
    logic [7:0] v;
    wr(2'd0, 1'b1, C_RISE | C_EXT);
    rd(2'd0, v);
    chk("R10 ctl readback", v, C_RISE | C_EXT);
    @(negedge clk); ext_pin = 1'b1;
    @(posedge clk); #1; chk("R2 edge1", {7'd0, wake_req}, 8'h00);
    @(posedge clk); #1; chk("R2 edge2", {7'd0, wake_req}, 8'h00);
    @(posedge clk); #1; chk("R2 edge3", {7'd0, wake_req}, 8'h01);
    rd(2'd1, v); chk("R2 flag set", v, 8'h01);
    wr(2'd1, 1'b0, 8'h01);
    @(negedge clk); ext_pin = 1'b0;
    idle(6);
    rd(2'd1, v); chk("R2 falling ignored", v, 8'h00);
  endtask

  task automatic t_ext_fall;
    logic [7:0] v;
    wr(2'd0, 1'b0, C_RISE);
    idle(3);
    rd(2'd1, v); chk("R3 select change", v, 8'h00);
    @(negedge clk); ext_pin = 1'b1;
    idle(6);
    rd(2'd1, v); chk("R3 rising ignored", v, 8'h00);
    @(negedge clk); ext_pin = 1'b0;
    idle(6);
    rd(2'd1, v); chk("R3 falling sets", v, 8'h01);
    wr(2'd1, 1'b0, 8'h01);
    wr(2'd0, 1'b0, C_EXT);
  endtask

  task automatic t_timer;
    logic [7:0] v;
    wr(2'd0, 1'b1, C_TMR);
    @(negedge clk); tmr_cnt = 8'hFF;
    @(negedge clk); tmr_cnt = 8'h01;
    @(posedge clk); #1; chk("R4 ff to 01", {7'd0, wake_req}, 8'h00);
    @(negedge clk); tmr_cnt = 8'hFE;
    @(negedge clk); tmr_cnt = 8'hFF;
    @(posedge clk); #1; chk("R4 fe to ff", {7'd0, wake_req}, 8'h00);
    @(negedge clk); tmr_cnt = 8'h00;
    @(posedge clk); #1; chk("R4 wrap", {7'd0, wake_req}, 8'h01);
    rd(2'd1, v); chk("R4 flag", v, 8'h02);
    wr(2'd1, 1'b0, 8'h02);
    wr(2'd0, 1'b0, C_TMR);
  endtask

  task automatic t_chg_per;
    logic [7:0] v;
    @(negedge clk); port_chg = 1'b1; periph_evt = 8'h05;
    @(posedge clk); #1; port_chg = 1'b0; periph_evt = 8'h00;
    chk("R6 no enable no wake", {7'd0, wake_req}, 8'h00);
    rd(2'd1, v); chk("R5 chg flag", v, 8'h04);
    rd(2'd3, v); chk("R5 per flags", v, 8'h05);
    idle(5);
    rd(2'd3, v); chk("R6 per flags held", v, 8'h05);
    wr(2'd3, 1'b0, 8'h05);
    rd(2'd3, v); chk("R6 per clear", v, 8'h00);
    wr(2'd3, 1'b1, 8'h80);
    rd(2'd3, v); chk("R6 per set by write", v, 8'h80);
    wr(2'd3, 1'b0, 8'h80);
  endtask

  task automatic t_collide;
    logic [7:0] v;
    @(negedge clk);
    port_chg = 1'b1;
    bus_wr = 1'b1; bus_op = 1'b0; bus_addr = 2'd1; bus_wdata = 8'h04;
    @(posedge clk); #1;
    port_chg = 1'b0; bus_wr = 1'b0;
    rd(2'd1, v); chk("R7 set beats clear", v, 8'h04);
    wr(2'd1, 1'b0, 8'h04);
    rd(2'd1, v); chk("R7 plain clear", v, 8'h00);
  endtask

  task automatic t_gating;
    @(negedge clk); periph_evt = 8'h08;
    @(posedge clk); #1; periph_evt = 8'h00;
    wr(2'd2, 1'b1, 8'h08);
    chk("R9 wake per", {7'd0, wake_req}, 8'h01);
    chk("R8 irq gbl off", {7'd0, irq_req}, 8'h00);
    wr(2'd0, 1'b1, C_GBL);
    chk("R8 irq grp off", {7'd0, irq_req}, 8'h00);
    chk("R9 wake grp off", {7'd0, wake_req}, 8'h01);
    wr(2'd0, 1'b1, C_PGRP);
    chk("R8 irq both on", {7'd0, irq_req}, 8'h01);
    wr(2'd0, 1'b0, C_GBL);
    chk("R8 irq gbl cleared", {7'd0, irq_req}, 8'h00);
    chk("R9 wake gbl cleared", {7'd0, wake_req}, 8'h01);
    wr(2'd2, 1'b0, 8'h08);
    chk("R9 wake en cleared", {7'd0, wake_req}, 8'h00);
    wr(2'd0, 1'b0, C_PGRP);
    wr(2'd1, 1'b1, 8'h01);
    wr(2'd0, 1'b1, C_GBL | C_EXT);
    chk("R8 core no grp", {7'd0, irq_req}, 8'h01);
    wr(2'd1, 1'b0, 8'h01);
    chk("R8 core cleared", {7'd0, irq_req}, 8'h00);
  endtask

  initial begin
    #2000000;
    miscompares++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    #1;
    t_reset();
    t_ext_rise();
    t_ext_fall();
    t_timer();
    t_chg_per();
    t_collide();
    t_gating();
    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule